// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches a 32-pin bank of general-purpose inputs and turns pin activity into interrupt requests. Each pin is configured on its own: it can report a rising transition, a falling transition, either transition, or a sustained level. A level can be chosen as active-high or active-low. Before detection, every pin passes through a small debounce stage. The stage accepts a new value only after the pin has held it for several samples. Software can bypass the stage pin by pin when it wants the fastest response.

A detected event sets a sticky bit in a status register. Software clears that bit by writing a 1 to it. An enable mask selects which status bits may raise the single combined interrupt line. A second, independent pair of registers does the same job for wake-up: a wake enable mask and a sticky wake status. The wake status drives its own output. All configuration and status sit behind a small synchronous register bus, with full-word writes and a combinational read.

The pins are assumed to be synchronous to the block clock already. Output drivers, direction control and any merging of several banks lie outside this block.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every register reads 0 and both `irq_out` and `wake_out` are low. With both edge-enable registers at 0, a pin change sets no status bit.
- R2: For a pin whose type bit is 0 (edge mode) and whose rising-enable bit is 1, a 0-to-1 change of the filtered input sets its status bit. With bypass, a pin value sampled at clock edge k shows up in status after edge k+1.
- R3: In edge mode, the falling-enable bit makes a 1-to-0 change set the status bit. With both enables set, either change sets it. With only the falling enable set, a rising change sets nothing.
- R4: A pin whose type bit is 1 (level mode) sets its status bit in every cycle in which its filtered level equals the active level. A polarity bit of 0 means active-high and 1 means active-low.
- R5: Writing the status register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R6: When a detection event and a software clear hit the same status bit in the same cycle, the bit stays set. A level pin that is still active therefore cannot be cleared.
- R7: `irq_out` is high exactly when some bit is set in both the status register and the interrupt mask. Status bits still latch while their mask bit is 0.
- R8: A bypass bit of 1 passes the pin straight to detection, one register stage. A bypass bit of 0 accepts a new pin value only after it has been sampled on 3 consecutive edges, so status sets after edge k+3. A pulse of 2 samples is discarded.
- R9: A wake-status bit sets on the same event as the status bit, but only where the wake-mask bit is 1. It clears when written as 1, and `wake_out` is the OR of all wake-status bits. Clearing wake status leaves interrupt status untouched.
- R10: The register addresses are: 0x00 rising enable, 0x04 falling enable, 0x08 type, 0x0C polarity, 0x10 interrupt mask, 0x14 status, 0x18 filter bypass, 0x1C wake mask, 0x20 wake status, and 0x24 filtered pin level. The level register is read-only. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Pin levels, synchronous to clk |
| bus_we | input | 1 | Write strobe, full-word write on the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_out | output | 1 | Combined interrupt request |
| wake_out | output | 1 | Combined wake request |

## Verification
A debounce counter that is off by one shows up as a 2-sample pulse that reaches status, or as a filtered level that appears in the level register one edge early or late. An edge-history register that holds the wrong value makes status bits appear with no pin change, or go missing, within two edges of the pin moving. Clear logic with the wrong priority shows at once: a level pin that is still active reads back 0 right after its clear. Wake gating that is crossed with the interrupt mask shows on `wake_out` in the same cycle the status bit sets.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADR_RISE_EN  = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_FALL_EN  = 8'h04;
  localparam logic [ADDR_W-1:0] ADR_TYPE     = 8'h08;
  localparam logic [ADDR_W-1:0] ADR_POL_LOW  = 8'h0C;
  localparam logic [ADDR_W-1:0] ADR_IRQ_MASK = 8'h10;
  localparam logic [ADDR_W-1:0] ADR_STATUS   = 8'h14;
  localparam logic [ADDR_W-1:0] ADR_BYPASS   = 8'h18;
  localparam logic [ADDR_W-1:0] ADR_WAKE_MSK = 8'h1C;
  localparam logic [ADDR_W-1:0] ADR_WAKE_STS = 8'h20;
  localparam logic [ADDR_W-1:0] ADR_LEVEL    = 8'h24;

endpackage

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
  parameter int unsigned NPINS         = 32,
  parameter int unsigned STABLE_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] raw,
  input  logic [NPINS-1:0] bypass,
  output logic [NPINS-1:0] filt
);

  localparam int unsigned CNT_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [CNT_W-1:0] cnt_q;
    logic             f_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        f_q   <= 1'b0;
      end else if (bypass[i]) begin
        cnt_q <= '0;
        f_q   <= raw[i];
      end else if (raw[i] == f_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        f_q   <= raw[i];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    assign filt[i] = f_q;

    if (STABLE_CYCLES == 3) begin : g_chk
      AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(f_q) != f_q) && !$past(bypass[i])) |->
        (($past(raw[i]) == f_q) && ($past(raw[i], 2) == f_q) && ($past(raw[i], 3) == f_q))); // R8
    end
  end

endmodule

// File: rtl/gpio_irq_event.sv
module gpio_irq_event #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] filt,
  input  logic [NPINS-1:0] rise_en,
  input  logic [NPINS-1:0] fall_en,
  input  logic [NPINS-1:0] lvl_type,
  input  logic [NPINS-1:0] lvl_low,
  output logic [NPINS-1:0] evt
);

  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] edge_hit;
  logic [NPINS-1:0] level_hit;

  function automatic logic [NPINS-1:0] edge_hits(
    input logic [NPINS-1:0] cur, input logic [NPINS-1:0] prv,
    input logic [NPINS-1:0] ren, input logic [NPINS-1:0] fen);
    return (cur & ~prv & ren) | (~cur & prv & fen);
  endfunction

  function automatic logic [NPINS-1:0] level_hits(
    input logic [NPINS-1:0] cur, input logic [NPINS-1:0] low);
    return cur ^ low;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= filt;
  end

  assign edge_hit  = edge_hits(filt, prev_q, rise_en, fall_en);
  assign level_hit = level_hits(filt, lvl_low);
  assign evt       = (edge_hit & ~lvl_type) | (level_hit & lvl_type);

  AST_EDGE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & ~lvl_type & ~rise_en & ~fall_en) == '0)); // R1

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  filt,
  input  logic [NPINS-1:0]  evt,
  output logic [NPINS-1:0]  rise_en,
  output logic [NPINS-1:0]  fall_en,
  output logic [NPINS-1:0]  lvl_type,
  output logic [NPINS-1:0]  lvl_low,
  output logic [NPINS-1:0]  bypass,
  output logic [NPINS-1:0]  irq_mask,
  output logic [NPINS-1:0]  status,
  output logic [NPINS-1:0]  wake_mask,
  output logic [NPINS-1:0]  wake_sts
);

  logic wr_sts, wr_wake;
  logic [NPINS-1:0] sts_clr, wake_clr;

  function automatic logic [NPINS-1:0] sticky_next(
    input logic [NPINS-1:0] cur, input logic [NPINS-1:0] clr,
    input logic [NPINS-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  assign wr_sts   = bus_we && (bus_addr == ADR_STATUS);
  assign wr_wake  = bus_we && (bus_addr == ADR_WAKE_STS);
  assign sts_clr  = wr_sts  ? bus_wdata : '0;
  assign wake_clr = wr_wake ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en   <= '0;
      fall_en   <= '0;
      lvl_type  <= '0;
      lvl_low   <= '0;
      bypass    <= '0;
      irq_mask  <= '0;
      wake_mask <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        ADR_RISE_EN:  rise_en   <= bus_wdata;
        ADR_FALL_EN:  fall_en   <= bus_wdata;
        ADR_TYPE:     lvl_type  <= bus_wdata;
        ADR_POL_LOW:  lvl_low   <= bus_wdata;
        ADR_BYPASS:   bypass    <= bus_wdata;
        ADR_IRQ_MASK: irq_mask  <= bus_wdata;
        ADR_WAKE_MSK: wake_mask <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status   <= '0;
      wake_sts <= '0;
    end else begin
      status   <= sticky_next(status, sts_clr, evt);
      wake_sts <= sticky_next(wake_sts, wake_clr, evt & wake_mask);
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_RISE_EN:  bus_rdata = rise_en;
      ADR_FALL_EN:  bus_rdata = fall_en;
      ADR_TYPE:     bus_rdata = lvl_type;
      ADR_POL_LOW:  bus_rdata = lvl_low;
      ADR_IRQ_MASK: bus_rdata = irq_mask;
      ADR_STATUS:   bus_rdata = status;
      ADR_BYPASS:   bus_rdata = bypass;
      ADR_WAKE_MSK: bus_rdata = wake_mask;
      ADR_WAKE_STS: bus_rdata = wake_sts;
      ADR_LEVEL:    bus_rdata = filt;
      default:      bus_rdata = '0;
    endcase
  end

  AST_STS_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & ~$past(evt)) == '0)); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sts |=> ((status & $past(bus_wdata) & ~$past(evt)) == '0)); // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sts |=> ((status & $past(evt)) == $past(evt))); // R6
  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((wake_sts & ~$past(wake_sts) & ~$past(wake_mask)) == '0)); // R9

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS         = 32,
  parameter int unsigned STABLE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic              irq_out,
  output logic              wake_out
);

  logic [NPINS-1:0] filt, evt;
  logic [NPINS-1:0] rise_en, fall_en, lvl_type, lvl_low, bypass;
  logic [NPINS-1:0] irq_mask, status, wake_mask, wake_sts;

  gpio_irq_filter #(.NPINS(NPINS), .STABLE_CYCLES(STABLE_CYCLES)) u_filter (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .bypass(bypass), .filt(filt)
  );

  gpio_irq_event #(.NPINS(NPINS)) u_event (
    .clk(clk), .rst_n(rst_n), .filt(filt), .rise_en(rise_en), .fall_en(fall_en),
    .lvl_type(lvl_type), .lvl_low(lvl_low), .evt(evt)
  );

  gpio_irq_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .filt(filt), .evt(evt),
    .rise_en(rise_en), .fall_en(fall_en), .lvl_type(lvl_type), .lvl_low(lvl_low),
    .bypass(bypass), .irq_mask(irq_mask), .status(status),
    .wake_mask(wake_mask), .wake_sts(wake_sts)
  );

  assign irq_out  = |(status & irq_mask);
  assign wake_out = |wake_sts;

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (irq_mask != '0)); // R7
  AST_WAKE_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_out) |-> ($past(wake_mask) != '0)); // R9

endmodule

// File: tb/gpio_irq_detect_tb_top.sv
module gpio_irq_detect_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_in = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out, wake_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  localparam logic [7:0] A_RISE = 8'h00, A_FALL = 8'h04, A_TYPE = 8'h08, A_POL = 8'h0C;
  localparam logic [7:0] A_MASK = 8'h10, A_STS = 8'h14, A_BYP = 8'h18, A_WMSK = 8'h1C;
  localparam logic [7:0] A_WSTS = 8'h20, A_LVL = 8'h24;

  always #2 clk = ~clk;

  gpio_irq_detect dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out), .wake_out(wake_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic set_pin(input int idx, input logic v);
    @(negedge clk);
    pin_in[idx] = v;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a <= 'h24; a += 4) begin
      rd(8'(a), v);
      chk("R1 reset register", v, 32'h0);
    end
    chk("R1 irq_out low", {31'b0, irq_out}, 32'h0);
    chk("R1 wake_out low", {31'b0, wake_out}, 32'h0);
    set_pin(0, 1'b1); step(5);
    rd(A_STS, v); chk("R1 no edge when enables zero", v, 32'h0);
    set_pin(0, 1'b0); step(5);
    rd(A_STS, v); chk("R1 no edge on fall either", v, 32'h0);
  endtask

  task automatic t_rise;
    logic [31:0] v;
    wr(A_BYP, 32'hFFFF_FFFF);
    wr(A_RISE, 32'h8);
    wr(A_MASK, 32'h8);
    set_pin(3, 1'b1); step(1);
    rd(A_STS, v); chk("R2 not yet after edge k", v, 32'h0);
    step(1);
    rd(A_STS, v); chk("R2 rising sets status after k+1", v, 32'h8);
    chk("R7 irq_out with mask", {31'b0, irq_out}, 32'h1);
    set_pin(3, 1'b0); step(2);
    rd(A_STS, v); chk("R2 status sticky", v, 32'h8);
    wr(A_STS, 32'h8);
    rd(A_STS, v); chk("R5 clear rising bit", v, 32'h0);
    chk("R7 irq_out drops", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_fall_both;
    logic [31:0] v;
    wr(A_FALL, 32'h20);
    set_pin(5, 1'b1); step(2);
    rd(A_STS, v); chk("R3 rising ignored with fall only", v, 32'h0);
    set_pin(5, 1'b0); step(2);
    rd(A_STS, v); chk("R3 falling sets", v, 32'h20);
    wr(A_STS, 32'h20);
    wr(A_RISE, 32'h88);
    wr(A_FALL, 32'hA0);
    set_pin(7, 1'b1); step(2);
    rd(A_STS, v); chk("R3 both edges: rise", v, 32'h80);
    wr(A_STS, 32'h80);
    set_pin(7, 1'b0); step(2);
    rd(A_STS, v); chk("R3 both edges: fall", v, 32'h80);
    wr(A_STS, 32'h80);
    wr(A_FALL, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    wr(A_POL, 32'h0);
    wr(A_TYPE, 32'h200);
    step(2);
    rd(A_STS, v); chk("R4 active-high idle low", v, 32'h0);
    set_pin(9, 1'b1); step(2);
    rd(A_STS, v); chk("R4 active-high sets", v, 32'h200);
    chk("R7 unmasked bit gives no irq", {31'b0, irq_out}, 32'h0);
    wr(A_MASK, 32'h208);
    chk("R7 irq after mask set", {31'b0, irq_out}, 32'h1);
    wr(A_STS, 32'h200);
    rd(A_STS, v); chk("R6 active level survives clear", v, 32'h200);
    set_pin(9, 1'b0); step(2);
    wr(A_STS, 32'h200);
    rd(A_STS, v); chk("R6 clears once level gone", v, 32'h0);
    wr(A_POL, 32'h400);
    wr(A_TYPE, 32'h400);
    step(1);
    rd(A_STS, v); chk("R4 active-low on low pin", v, 32'h400);
    set_pin(10, 1'b1); step(2);
    wr(A_STS, 32'h400);
    rd(A_STS, v); chk("R4 active-low inactive when high", v, 32'h0);
    wr(A_TYPE, 32'h0);
    wr(A_POL, 32'h0);
    set_pin(10, 1'b0); step(2);
    wr(A_MASK, 32'h8);
  endtask

  task automatic t_filter;
    logic [31:0] v;
    wr(A_BYP, ~32'h1000);
    wr(A_RISE, 32'h1000);
    set_pin(12, 1'b1); step(1);
    set_pin(12, 1'b0); step(4);
    rd(A_STS, v); chk("R8 2-sample pulse dropped", v, 32'h0);
    rd(A_LVL, v); chk("R8 filtered level stays low", v, 32'h0);
    set_pin(12, 1'b1); step(2);
    rd(A_LVL, v); chk("R8 level not yet at k+1", v, 32'h0);
    step(1);
    rd(A_LVL, v); chk("R8 level after 3 samples", v, 32'h1000);
    rd(A_STS, v); chk("R8 status not yet at k+2", v, 32'h0);
    step(1);
    rd(A_STS, v); chk("R8 status at k+3", v, 32'h1000);
    wr(A_STS, 32'h1000);
  endtask

  task automatic t_wake;
    logic [31:0] v;
    wr(A_RISE, 32'h88);
    wr(A_WMSK, 32'h8);
    set_pin(3, 1'b1);
    set_pin(7, 1'b1); step(2);
    rd(A_STS, v); chk("R9 status both pins", v, 32'h88);
    rd(A_WSTS, v); chk("R9 wake only masked pin", v, 32'h8);
    chk("R9 wake_out high", {31'b0, wake_out}, 32'h1);
    wr(A_WSTS, 32'h8);
    rd(A_WSTS, v); chk("R9 wake cleared", v, 32'h0);
    chk("R9 wake_out low", {31'b0, wake_out}, 32'h0);
    rd(A_STS, v); chk("R9 status untouched by wake clear", v, 32'h88);
    wr(A_STS, 32'h0);
    rd(A_STS, v); chk("R5 zero write keeps bits", v, 32'h88);
    wr(A_STS, 32'h8);
    rd(A_STS, v); chk("R5 only written bit clears", v, 32'h80);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(A_WMSK, 32'hA5A5_0000);
    rd(A_WMSK, v); chk("R10 wake mask readback", v, 32'hA5A5_0000);
    wr(A_LVL, 32'hFFFF_FFFF);
    rd(A_LVL, v); chk("R10 level read-only", v, 32'h0000_1088);
    rd(8'h3C, v); chk("R10 unmapped reads zero", v, 32'h0);
    rd(A_RISE, v); chk("R10 rise enable readback", v, 32'h88);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_rise();
    t_fall_both();
    t_level();
    t_filter();
    t_wake();
    t_map();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule